// File: doc/BRIEF.md
# Shared-Bus Address and Write-Data Multiplexor

This block is the central routing point of a shared bus that serves up to sixteen masters. Each master drives its own address, control, lock indication and write data at every cycle, whether or not it owns the bus. A 4-bit owner number, supplied by an external arbiter, picks which master's address, control and lock lines reach every slave in the same cycle. Because of this, a master can place its next address on its lines early. The routing logic, not the master, decides what the slaves see.

The write data belongs to the transfer whose address was accepted one cycle earlier. To follow it, the block keeps its own registered copy of the owner number, the data-phase owner. This copy loads the current owner number only on a rising clock edge with the ready input high. While a slave inserts wait states, the data-phase owner therefore stays on the master whose transfer is still completing, even if the address lines have already moved to a new master.

The design has one piece of state, the data-phase owner register. Async reset sets it to master 0. On each rising edge, one of two transitions applies. "Load" takes the owner number when ready is high. "Hold" keeps the old value when ready is low. An owner number at or above the configured master count selects nothing, and the affected outputs read as zero.

Top module: `shbus_route`

## Requirements
- R1: `bus_addr_o` equals the address of the master whose index is `owner_i`, in the same cycle, with no register in the path.
- R2: `bus_ctrl_o` equals the control bundle of the master indexed by `owner_i`, in the same cycle.
- R3: `bus_lock_o` equals the lock bit of the master indexed by `owner_i`, with exactly the same timing as the address.
- R4: When `owner_i` is NUM_MST or above, address, control and lock outputs are all zero. When the data-phase owner is NUM_MST or above, `bus_wdata_o` is zero.
- R5: On a rising edge with `ready_i` high, the data-phase owner takes the value of `owner_i`. `bus_wdata_o` is then the write data of the master indexed by the data-phase owner.
- R6: On a rising edge with `ready_i` low, the data-phase owner keeps its value. During a wait-stated data phase, write data therefore stays on the previous owner while the address already shows the new owner.
- R7: While `rst_n` is low, the data-phase owner is 0, so `bus_wdata_o` carries master 0's write data. The address path keeps following `owner_i` during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| owner_i | input | 4 | Number of the master owning the address phase |
| ready_i | input | 1 | Transfer-accepted signal from the selected slave |
| mst_addr_i | input | NUM_MST x ADDR_W | Address driven by each master |
| mst_ctrl_i | input | NUM_MST x CTRL_W | Control bundle driven by each master |
| mst_lock_i | input | NUM_MST | Locked-sequence bit from each master |
| mst_wdata_i | input | NUM_MST x DATA_W | Write data driven by each master |
| bus_addr_o | output | ADDR_W | Address sent to all slaves |
| bus_ctrl_o | output | CTRL_W | Control sent to all slaves |
| bus_lock_o | output | 1 | Locked-transfer indication sent to all slaves |
| bus_wdata_o | output | DATA_W | Write data sent to all slaves |

## Verification
The assertions assume that `owner_i` and `ready_i` are always known values and that reset is held low for at least one rising edge before operation. They also assume that an out-of-range owner number is legal input and simply selects nothing. The stimulus changes every input only on the falling edge and draws owner numbers over the full range from 0 to 7. With the default six masters, this regularly produces invalid selections. Ready is randomised at roughly a 70 percent duty, so runs of consecutive wait states occur both with and without a change of owner.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
    localparam int SEL_W   = 4;
    localparam int MAX_MST = 1 << SEL_W;

    typedef logic [SEL_W-1:0] mst_id_t;
endpackage

// File: rtl/shbus_pick.sv
module shbus_pick
    import shbus_pkg::*;
#(
    parameter int N = 6,
    parameter int W = 32
) (
    input  logic [N-1:0][W-1:0] lanes_i,
    input  mst_id_t             sel_i,
    output logic [W-1:0]        lane_o
);
    logic [N-1:0] hit;

    // one comparator per lane; an index with no lane leaves every hit low
    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = (sel_i == SEL_W'(g));
    end

    always_comb begin
        lane_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                lane_o = lane_o | lanes_i[i];
            end
        end
    end
endmodule

// File: rtl/shbus_dphase.sv
module shbus_dphase
    import shbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ready_i,
    input  mst_id_t owner_i,
    output mst_id_t dp_owner_o
);
    mst_id_t dp_q;
    mst_id_t dp_d;

    always_comb begin
        dp_d = ready_i ? owner_i : dp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign dp_owner_o = dp_q;
endmodule

// File: rtl/shbus_route.sv
module shbus_route
    import shbus_pkg::*;
#(
    parameter int NUM_MST = 6,
    parameter int ADDR_W  = 32,
    parameter int CTRL_W  = 14,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [3:0]                      owner_i,
    input  logic                            ready_i,
    input  logic [NUM_MST-1:0][ADDR_W-1:0]  mst_addr_i,
    input  logic [NUM_MST-1:0][CTRL_W-1:0]  mst_ctrl_i,
    input  logic [NUM_MST-1:0]              mst_lock_i,
    input  logic [NUM_MST-1:0][DATA_W-1:0]  mst_wdata_i,
    output logic [ADDR_W-1:0]               bus_addr_o,
    output logic [CTRL_W-1:0]               bus_ctrl_o,
    output logic                            bus_lock_o,
    output logic [DATA_W-1:0]               bus_wdata_o
);
    mst_id_t                 dp_owner_q;
    logic [NUM_MST-1:0][0:0] lock_lanes;
    logic [0:0]              lock_sel;

    for (genvar g = 0; g < NUM_MST; g++) begin : g_lock
        assign lock_lanes[g] = mst_lock_i[g];
    end

    shbus_dphase u_dphase (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_i),
        .owner_i    (owner_i),
        .dp_owner_o (dp_owner_q)
    );

    shbus_pick #(.N(NUM_MST), .W(ADDR_W)) u_addr (
        .lanes_i (mst_addr_i),
        .sel_i   (owner_i),
        .lane_o  (bus_addr_o)
    );

    shbus_pick #(.N(NUM_MST), .W(CTRL_W)) u_ctrl (
        .lanes_i (mst_ctrl_i),
        .sel_i   (owner_i),
        .lane_o  (bus_ctrl_o)
    );

    shbus_pick #(.N(NUM_MST), .W(1)) u_lock (
        .lanes_i (lock_lanes),
        .sel_i   (owner_i),
        .lane_o  (lock_sel)
    );

    shbus_pick #(.N(NUM_MST), .W(DATA_W)) u_wdata (
        .lanes_i (mst_wdata_i),
        .sel_i   (dp_owner_q),
        .lane_o  (bus_wdata_o)
    );

    assign bus_lock_o = lock_sel[0];
endmodule

// File: rtl/shbus_route_chk.sv
module shbus_route_chk #(
    parameter int NUM_MST = 6,
    parameter int ADDR_W  = 32,
    parameter int CTRL_W  = 14,
    parameter int DATA_W  = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [3:0]                      owner_i,
    input logic                            ready_i,
    input logic [NUM_MST-1:0][ADDR_W-1:0]  mst_addr_i,
    input logic [NUM_MST-1:0][CTRL_W-1:0]  mst_ctrl_i,
    input logic [NUM_MST-1:0]              mst_lock_i,
    input logic [NUM_MST-1:0][DATA_W-1:0]  mst_wdata_i,
    input logic [ADDR_W-1:0]               bus_addr_o,
    input logic [CTRL_W-1:0]               bus_ctrl_o,
    input logic                            bus_lock_o,
    input logic [DATA_W-1:0]               bus_wdata_o,
    input logic [3:0]                      dp_owner
);
    for (genvar g = 0; g < NUM_MST; g++) begin : g_lane
        a_r1_addr_route : assert property (@(posedge clk) disable iff (!rst_n)
            (owner_i == 4'(g)) |-> (bus_addr_o == mst_addr_i[g]));
        a_r2_ctrl_route : assert property (@(posedge clk) disable iff (!rst_n)
            (owner_i == 4'(g)) |-> (bus_ctrl_o == mst_ctrl_i[g]));
        a_r3_lock_route : assert property (@(posedge clk) disable iff (!rst_n)
            (owner_i == 4'(g)) |-> (bus_lock_o == mst_lock_i[g]));
        a_r5_wdata_route : assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ready_i) && ($past(owner_i) == 4'(g)))
            |-> (bus_wdata_o == mst_wdata_i[g]));
    end

    a_r4_no_owner : assert property (@(posedge clk) disable iff (!rst_n)
        (int'(owner_i) >= NUM_MST)
        |-> (bus_addr_o == '0 && bus_ctrl_o == '0 && !bus_lock_o));

    a_r5_load : assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> (dp_owner == $past(owner_i)));

    a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(dp_owner));
endmodule

bind shbus_route shbus_route_chk #(
    .NUM_MST (NUM_MST),
    .ADDR_W  (ADDR_W),
    .CTRL_W  (CTRL_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .owner_i     (owner_i),
    .ready_i     (ready_i),
    .mst_addr_i  (mst_addr_i),
    .mst_ctrl_i  (mst_ctrl_i),
    .mst_lock_i  (mst_lock_i),
    .mst_wdata_i (mst_wdata_i),
    .bus_addr_o  (bus_addr_o),
    .bus_ctrl_o  (bus_ctrl_o),
    .bus_lock_o  (bus_lock_o),
    .bus_wdata_o (bus_wdata_o),
    .dp_owner    (dp_owner_q)
);

// File: tb/shbus_route_test.sv
module shbus_route_test;
    localparam int N  = 6;
    localparam int AW = 32;
    localparam int CW = 14;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n;
    logic [3:0]             owner;
    logic                   ready;
    logic [N-1:0][AW-1:0]   m_addr;
    logic [N-1:0][CW-1:0]   m_ctrl;
    logic [N-1:0]           m_lock;
    logic [N-1:0][DW-1:0]   m_wdata;
    logic [AW-1:0]          b_addr;
    logic [CW-1:0]          b_ctrl;
    logic                   b_lock;
    logic [DW-1:0]          b_wdata;

    int n_cmp  = 0;
    int n_bad  = 0;
    int exp_dp = 0;
    bit done   = 1'b0;

    shbus_route #(.NUM_MST(N), .ADDR_W(AW), .CTRL_W(CW), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .owner_i     (owner),
        .ready_i     (ready),
        .mst_addr_i  (m_addr),
        .mst_ctrl_i  (m_ctrl),
        .mst_lock_i  (m_lock),
        .mst_wdata_i (m_wdata),
        .bus_addr_o  (b_addr),
        .bus_ctrl_o  (b_ctrl),
        .bus_lock_o  (b_lock),
        .bus_wdata_o (b_wdata)
    );

    function automatic logic [AW-1:0] e_addr(int o);
        return (o < N) ? m_addr[o] : '0;
    endfunction
    function automatic logic [CW-1:0] e_ctrl(int o);
        return (o < N) ? m_ctrl[o] : '0;
    endfunction
    function automatic logic e_lock(int o);
        return (o < N) ? m_lock[o] : 1'b0;
    endfunction
    function automatic logic [DW-1:0] e_wdata(int o);
        return (o < N) ? m_wdata[o] : '0;
    endfunction

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic scramble();
        for (int i = 0; i < N; i++) begin
            m_addr[i]  = $urandom();
            m_ctrl[i]  = CW'($urandom());
            m_lock[i]  = 1'($urandom());
            m_wdata[i] = $urandom();
        end
    endtask

    // R1..R4 on the address side, R4/R5/R6/R7 on the data side
    task automatic check_all(string dreq);
        string areq;
        areq = (int'(owner) < N) ? "R1" : "R4";
        cmp(areq, "addr", 64'(b_addr), 64'(e_addr(int'(owner))));
        cmp((int'(owner) < N) ? "R2" : "R4", "ctrl", 64'(b_ctrl), 64'(e_ctrl(int'(owner))));
        cmp((int'(owner) < N) ? "R3" : "R4", "lock", 64'(b_lock), 64'(e_lock(int'(owner))));
        cmp((exp_dp < N) ? dreq : "R4", "wdata", 64'(b_wdata), 64'(e_wdata(exp_dp)));
    endtask

    // one rising edge, model update, then back to the falling edge
    task automatic step();
        @(posedge clk);
        if (rst_n && ready) exp_dp = int'(owner);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        owner = 4'd3;
        ready = 1'b1;
        scramble();
        @(negedge clk);
        repeat (3) step();
        #5;
        check_all("R7");

        // R7: data owner stays 0 while in reset, whatever ready/owner do
        scramble();
        #5;
        check_all("R7");
        @(negedge clk);
        rst_n = 1'b1;

        // R5: load owner 1 through an accepted transfer
        owner = 4'd1;
        ready = 1'b1;
        step();
        #5;
        check_all("R5");

        // R6: wait state, address moves to master 2, data stays on master 1
        @(negedge clk);
        owner = 4'd2;
        ready = 1'b0;
        #5;
        check_all("R6");
        cmp("R6", "wdata_prev_owner", 64'(b_wdata), 64'(m_wdata[1]));
        cmp("R6", "addr_new_owner", 64'(b_addr), 64'(m_addr[2]));
        step();
        scramble();
        #5;
        check_all("R6");
        cmp("R6", "wdata_held", 64'(b_wdata), 64'(m_wdata[1]));
        @(negedge clk);
        ready = 1'b1;
        step();
        #5;
        check_all("R5");
        cmp("R5", "wdata_after_wait", 64'(b_wdata), 64'(m_wdata[2]));

        // R4: owner number beyond the master count
        @(negedge clk);
        owner = 4'd15;
        ready = 1'b1;
        #5;
        check_all("R5");
        cmp("R4", "addr_zero", 64'(b_addr), 64'd0);
        step();
        #5;
        check_all("R4");
        cmp("R4", "wdata_zero", 64'(b_wdata), 64'd0);

        // highest valid master
        @(negedge clk);
        owner = 4'(N - 1);
        step();
        #5;
        check_all("R5");

        // constrained random: owners 0..7, ready about 70 percent
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            scramble();
            owner = 4'($urandom_range(7, 0));
            ready = ($urandom_range(9, 0) < 7);
            #5;
            check_all(ready ? "R5" : "R6");
            step();
            #5;
            check_all("R5");
        end

        // R7: asynchronous reset mid-run sends write data back to master 0
        @(negedge clk);
        owner = 4'd4;
        ready = 1'b1;
        rst_n = 1'b0;
        exp_dp = 0;
        #5;
        check_all("R7");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule